// File: doc/BRIEF.md
# In-Order Three-Slot Issue Grouper

The block sits between instruction decode and three execution pipelines: an address pipe, an integer pipe and a loop pipe. Each cycle it inspects the three oldest decoded entries of one in-order instruction stream. Each entry arrives with a valid flag, a 2-bit class and an instruction word. The block picks the longest leading run of entries that may leave together, where the classes must rise strictly through address, integer, loop. It reports the length of that run to the instruction buffer as a combinational pop count. One cycle later it presents every issued instruction on the pipe that matches its class, with a valid strobe, together with a registered issue count.

Grouping looks only at valid flags and classes. Two instructions in one group issue together even when one consumes the other's result; later pipeline stages resolve that. Every entry the buffer pops appears on exactly one pipe, so instructions in branch or memory delay slots are never dropped.

Top module: `isg_top`

## Requirements
- R1: When the head entry is valid and `stall` is low, `pop_cnt` is at least 1.
- R2: When `stall` is high, `pop_cnt` is 0, and in the next cycle all three pipe valids are low and `issue_cnt` is 0.
- R3: Grouping ends at the first invalid entry. An invalid head gives `pop_cnt` 0, and a valid entry behind a gap never joins the group.
- R4: Classes are encoded 00 address (rank 0), 01 integer (rank 1), 10 loop (rank 2), 11 other (treated as integer, rank 1). An entry joins the group only when its rank is strictly greater than the rank of the entry before it. Equal or falling rank ends the group.
- R5: Instruction words have no effect on grouping. Two inputs with equal valids and classes give the same `pop_cnt`, whatever the words hold.
- R6: One cycle after a pop, each popped entry appears on the pipe of its rank (0 address, 1 integer, 2 loop) with its unchanged word, and pipes that receive no entry show valid low.
- R7: `issue_cnt` equals the `pop_cnt` of the previous cycle and equals the number of pipe valids that are high. No popped entry is lost.
- R8: A synchronous active-low `rst_n` clears all pipe valids and `issue_cnt` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Global stall; blocks all issue this cycle |
| in_vld | input | 3 | Entry valid flags, bit 0 is the oldest entry |
| in_cls | input | 6 | Entry classes, two bits per entry, bits [1:0] oldest |
| in_word | input | 96 | Entry words, 32 bits per entry, bits [31:0] oldest |
| pop_cnt | output | 2 | Entries consumed this cycle (combinational) |
| agu_vld | output | 1 | Address pipe valid |
| agu_word | output | 32 | Address pipe instruction word |
| alu_vld | output | 1 | Integer pipe valid |
| alu_word | output | 32 | Integer pipe instruction word |
| lp_vld | output | 1 | Loop pipe valid |
| lp_word | output | 32 | Loop pipe instruction word |
| issue_cnt | output | 2 | Number of instructions issued this cycle (registered) |

## Verification
The assertions assume that the buffer delivers valid, class and stall as settled values before each rising edge, and that the entry set of one cycle is independent of the pop count decided in the same cycle. Nothing else is assumed about the inputs: any valid pattern, including gaps, and any class triple is legal. The bench changes inputs only on the falling edge. It covers all 64 class triples with every entry valid and the gap patterns with directed vectors, then applies random valids, classes, words and occasional stalls from a fixed seed, so every input stays within what the checker presumes.

// File: rtl/isg_pkg.sv
// Package: shared types and helpers for the issue grouper.
// Assumes the 2-bit class code of the decode stage: 00 address,
// 01 integer, 10 loop, 11 other (steered as integer).
package isg_pkg;

    localparam int NSLOT = 3;          // entries inspected and pipes served
    localparam int CLS_W = 2;          // class code width

    typedef enum logic [1:0] {
        RK_ADDR = 2'd0,
        RK_INT  = 2'd1,
        RK_LOOP = 2'd2
    } isg_rank_e;

    // Map a class code to its pipe rank.
    function automatic isg_rank_e cls_to_rank(input logic [CLS_W-1:0] cls);
        case (cls)
            2'b00:   return RK_ADDR;
            2'b10:   return RK_LOOP;
            default: return RK_INT;
        endcase
    endfunction

endpackage

// File: rtl/isg_rank_decode.sv
// Module: turns each entry's class code into a pipe rank.
// Assumes NSLOT entries packed oldest first.
module isg_rank_decode
    import isg_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  logic [N*CLS_W-1:0] cls,
    output logic [N-1:0][1:0]  rank
);
    for (genvar k = 0; k < N; k++) begin : g_slot
        // Per-slot class to rank conversion.
        always_comb rank[k] = cls_to_rank(cls[k*CLS_W +: CLS_W]);
    end
endmodule

// File: rtl/isg_group_len.sv
// Module: finds the length of the leading run of entries that may
// issue together. Assumes three entries, ranks already decoded.
// A run needs valid entries with strictly rising rank; stall forces 0.
module isg_group_len (
    input  logic            stall,
    input  logic [2:0]      vld,
    input  logic [2:0][1:0] rank,
    output logic [1:0]      len
);
    logic join1;
    logic join2;

    // Decide whether entries 1 and 2 extend the group.
    always_comb begin
        join1 = vld[1] && (rank[1] > rank[0]);
        join2 = join1 && vld[2] && (rank[2] > rank[1]);
    end

    // Count the group, suppressed by stall or an invalid head.
    always_comb begin
        if (stall || !vld[0])
            len = 2'd0;
        else
            len = 2'd1 + {1'b0, join1} + {1'b0, join2};
    end
endmodule

// File: rtl/isg_steer.sv
// Module: routes each grouped entry to the pipe of its rank.
// Assumes the group has strictly rising ranks, so no two grouped
// entries target the same pipe.
module isg_steer #(
    parameter int WORD_W = 32,
    parameter int N      = 3
) (
    input  logic [1:0]          len,
    input  logic [N-1:0][1:0]   rank,
    input  logic [N*WORD_W-1:0] word,
    output logic [N-1:0]        pipe_vld,
    output logic [N*WORD_W-1:0] pipe_word
);
    for (genvar p = 0; p < N; p++) begin : g_pipe
        // Gather the grouped entry, if any, whose rank equals this pipe.
        always_comb begin
            pipe_vld[p]                 = 1'b0;
            pipe_word[p*WORD_W +: WORD_W] = '0;
            for (int k = 0; k < N; k++) begin
                if ((k < int'(len)) && (int'(rank[k]) == p)) begin
                    pipe_vld[p]                   = 1'b1;
                    pipe_word[p*WORD_W +: WORD_W] = word[k*WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/isg_issue_reg.sv
// Module: output register stage for pipe valids, words and count.
// Assumes synchronous active-low reset; words are not reset.
module isg_issue_reg #(
    parameter int WORD_W = 32,
    parameter int N      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        vld_d,
    input  logic [N*WORD_W-1:0] word_d,
    input  logic [1:0]          cnt_d,
    output logic [N-1:0]        vld_q,
    output logic [N*WORD_W-1:0] word_q,
    output logic [1:0]          cnt_q
);
    // Register valids and count with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            cnt_q <= '0;
        end else begin
            vld_q <= vld_d;
            cnt_q <= cnt_d;
        end
    end

    // Register words without reset; qualified by the valids.
    always_ff @(posedge clk) begin
        word_q <= word_d;
    end
endmodule

// File: rtl/isg_top.sv
// Module: three-slot in-order issue grouper. Picks the leading run of
// up to three entries whose ranks rise address, integer, loop, reports
// it as a combinational pop count and issues it registered to the pipes.
// Assumes entries are packed oldest first and settle before each edge.
module isg_top #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stall,
    input  logic [2:0]          in_vld,
    input  logic [5:0]          in_cls,
    input  logic [3*WORD_W-1:0] in_word,
    output logic [1:0]          pop_cnt,
    output logic                agu_vld,
    output logic [WORD_W-1:0]   agu_word,
    output logic                alu_vld,
    output logic [WORD_W-1:0]   alu_word,
    output logic                lp_vld,
    output logic [WORD_W-1:0]   lp_word,
    output logic [1:0]          issue_cnt
);
    import isg_pkg::*;

    localparam int N = NSLOT;

    logic [N-1:0][1:0]   rank;
    logic [1:0]          len;
    logic [N-1:0]        steer_vld;
    logic [N*WORD_W-1:0] steer_word;
    logic [N-1:0]        q_vld;
    logic [N*WORD_W-1:0] q_word;

    isg_rank_decode #(.N(N)) u_rank (
        .cls  (in_cls),
        .rank (rank)
    );

    isg_group_len u_len (
        .stall (stall),
        .vld   (in_vld),
        .rank  (rank),
        .len   (len)
    );

    isg_steer #(.WORD_W(WORD_W), .N(N)) u_steer (
        .len       (len),
        .rank      (rank),
        .word      (in_word),
        .pipe_vld  (steer_vld),
        .pipe_word (steer_word)
    );

    isg_issue_reg #(.WORD_W(WORD_W), .N(N)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_d  (steer_vld),
        .word_d (steer_word),
        .cnt_d  (len),
        .vld_q  (q_vld),
        .word_q (q_word),
        .cnt_q  (issue_cnt)
    );

    // Expose the pop count and split the registered pipes by rank.
    always_comb begin
        pop_cnt  = len;
        agu_vld  = q_vld[RK_ADDR];
        alu_vld  = q_vld[RK_INT];
        lp_vld   = q_vld[RK_LOOP];
        agu_word = q_word[int'(RK_ADDR)*WORD_W +: WORD_W];
        alu_word = q_word[int'(RK_INT)*WORD_W +: WORD_W];
        lp_word  = q_word[int'(RK_LOOP)*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/isg_top_chk.sv
// Checker: temporal properties of the issue grouper, bound to isg_top.
// Assumes inputs settle before each rising edge.
module isg_top_chk #(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stall,
    input logic [2:0]          in_vld,
    input logic [5:0]          in_cls,
    input logic [3*WORD_W-1:0] in_word,
    input logic [1:0]          pop_cnt,
    input logic                agu_vld,
    input logic [WORD_W-1:0]   agu_word,
    input logic                alu_vld,
    input logic [WORD_W-1:0]   alu_word,
    input logic                lp_vld,
    input logic [WORD_W-1:0]   lp_word,
    input logic [1:0]          issue_cnt
);
    assert_head_issues_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[0] && !stall) |-> (pop_cnt != 2'd0));

    assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!agu_vld && !alu_vld && !lp_vld && issue_cnt == 2'd0));

    assert_invalid_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld[0] |-> (pop_cnt == 2'd0));

    assert_gap_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[0] && !in_vld[1] && !stall) |-> (pop_cnt == 2'd1));

    assert_same_class_splits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[0] && !stall && in_cls[1:0] == in_cls[3:2]) |-> (pop_cnt == 2'd1));

    assert_count_follows_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (issue_cnt == $past(pop_cnt)));

    assert_count_matches_valids_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({agu_vld, alu_vld, lp_vld}) == int'(issue_cnt)));

    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!agu_vld && !alu_vld && !lp_vld && issue_cnt == 2'd0));
endmodule

bind isg_top isg_top_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_isg_top.sv
// Bench: directed class triples and gaps, then seeded random vectors,
// compared against a grouping model written from the requirements.
module tb_isg_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stall;
    logic [2:0]    in_vld;
    logic [5:0]    in_cls;
    logic [3*W-1:0] in_word;
    logic [1:0]    pop_cnt;
    logic          agu_vld, alu_vld, lp_vld;
    logic [W-1:0]  agu_word, alu_word, lp_word;
    logic [1:0]    issue_cnt;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    isg_top #(.WORD_W(W)) dut (.*);

    // Rank per class: 00->0, 01->1, 10->2, 11->1.
    function automatic int rank_of(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
    endfunction

    // Expected group length from valids, classes and stall.
    function automatic int exp_len(input logic [2:0] v, input logic [5:0] c, input logic s);
        int n;
        if (s || !v[0]) return 0;
        n = 1;
        if (v[1] && rank_of(c[3:2]) > rank_of(c[1:0])) begin
            n = 2;
            if (v[2] && rank_of(c[5:4]) > rank_of(c[3:2])) n = 3;
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one vector and check pop count, then registered pipes.
    task automatic apply(input logic [2:0] v, input logic [5:0] c,
                         input logic [3*W-1:0] w, input logic s);
        int          len;
        logic [2:0]  ev;
        logic [W-1:0] ew [3];
        @(negedge clk);
        in_vld = v; in_cls = c; in_word = w; stall = s;
        #1;
        len = exp_len(v, c, s);
        check(int'(pop_cnt) == len, s ? "R2" : "R1/R3/R4", int'(pop_cnt), len);
        ev = '0;
        for (int p = 0; p < 3; p++) ew[p] = '0;
        for (int k = 0; k < len; k++) begin
            ev[rank_of(c[2*k +: 2])]  = 1'b1;
            ew[rank_of(c[2*k +: 2])]  = w[k*W +: W];
        end
        @(posedge clk);
        #1;
        check({lp_vld, alu_vld, agu_vld} == ev, "R6", int'({lp_vld, alu_vld, agu_vld}), int'(ev));
        if (ev[0]) check(agu_word == ew[0], "R6", int'(agu_word), int'(ew[0]));
        if (ev[1]) check(alu_word == ew[1], "R6", int'(alu_word), int'(ew[1]));
        if (ev[2]) check(lp_word  == ew[2], "R6", int'(lp_word),  int'(ew[2]));
        check(int'(issue_cnt) == len, "R7", int'(issue_cnt), len);
    endtask

    function automatic logic [3*W-1:0] rnd_words();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        logic [1:0] p_a, p_b;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; stall = 1'b0;
        in_vld = 3'b111; in_cls = 6'b100100; in_word = rnd_words();
        repeat (3) @(posedge clk);
        #1;
        check(!agu_vld && !alu_vld && !lp_vld, "R8", int'({lp_vld, alu_vld, agu_vld}), 0);
        check(issue_cnt == 2'd0, "R8", int'(issue_cnt), 0);
        @(negedge clk); rst_n = 1'b1;

        // R4: every class triple, all entries valid.
        for (int t = 0; t < 64; t++) apply(3'b111, 6'(t), rnd_words(), 1'b0);
        // R3: gaps and invalid heads with a fully ordered triple.
        for (int v = 0; v < 8; v++) apply(3'(v), 6'b100100, rnd_words(), 1'b0);
        // R2: stall with a full ordered group.
        apply(3'b111, 6'b100100, rnd_words(), 1'b1);
        // R5: same valids and classes, different words, same pop count.
        apply(3'b111, 6'b110100, '0, 1'b0);
        @(negedge clk); in_word = '0; #1; p_a = pop_cnt;
        in_word = '1; #1; p_b = pop_cnt;
        check(p_a == p_b && p_a == 2'd2, "R5", int'(p_b), 2);
        // R8: reset in mid-stream clears issued state.
        @(negedge clk); rst_n = 1'b0; in_vld = 3'b111; in_cls = 6'b100100;
        @(posedge clk); #1;
        check(!agu_vld && !alu_vld && !lp_vld && issue_cnt == 0, "R8",
              int'({issue_cnt, lp_vld, alu_vld, agu_vld}), 0);
        @(negedge clk); rst_n = 1'b1;

        // Random mix, stall about one vector in eight.
        for (int i = 0; i < 3000; i++)
            apply(3'($urandom()), 6'($urandom()), rnd_words(), ($urandom() % 8) == 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule